// File: doc/BRIEF.md
# UART DMA Handshake and Interrupt Unit

This unit connects a UART core to two DMA channels, one that drains the receiver and one that feeds the transmitter. It moves exactly one character per request/acknowledge handshake through the UART's own holding registers and adds no buffering of its own. In DMA mode a transmit request is raised whenever the transmit holding register is empty. A receive request is raised whenever a received character is waiting.

Each channel has a latched interrupt status that software clears by writing ones. The transmit interrupt is driven only by transmit DMA completion. The receive interrupt combines receive DMA completion with receive error conditions, and the errors count only when an error-enable input is set. A 2-bit counter reports how many DMA-loaded characters are still in the transmitter. A change between processor-driven and DMA-driven operation is held off until the transmitter is fully drained.

Top module: `uart_dma_bridge`

## Requirements
- R1: After a synchronous active-low reset the unit is in processor mode (`dma_mode`=0), both DMA requests are low, `irq_status` is 0, both interrupt outputs are low and `tx_buf_status` is 0.
- R2: In DMA mode with `thr_empty` high, `tx_dma_req` is high one cycle later. In a cycle where `tx_dma_ack` meets a high `tx_dma_req`, `thr_load` is high in that same cycle and `thr_data` equals `tx_dma_data`. `tx_dma_req` is low in the following cycle.
- R3: In DMA mode with `rx_valid` high, `rx_dma_req` is high one cycle later. In a cycle where `rx_dma_ack` meets a high `rx_dma_req`, `rx_take` is high in that same cycle and `rx_dma_data` equals `rx_data`. `rx_dma_req` is low in the following cycle.
- R4: An acknowledge that arrives while the matching request is low has no effect: `thr_load` and `rx_take` stay low.
- R5: In processor mode neither DMA request is raised, whatever the state of `thr_empty` and `rx_valid`.
- R6: A pulse on `tx_dma_done` sets `irq_status[2]` and a pulse on `rx_dma_done` sets `irq_status[0]`, both one cycle later. `tx_irq` equals `irq_status[2]`, independent of all receive-side inputs.
- R7: Any bit of `rx_err` (overrun, parity, framing, break) sets `irq_status[1]` one cycle later only while `rx_err_irq_en` is high. `rx_irq` is the OR of `irq_status[0]` and `irq_status[1]`.
- R8: A cycle with `irq_clr_wr` high clears each `irq_status` bit whose `irq_clr_data` bit is one. Bits written with zero are left unchanged, and set bits stay set until cleared.
- R9: When an event and a clear for the same status bit fall in the same cycle, the bit ends up set.
- R10: `tx_buf_status` counts up by one on each `thr_load` and down by one on each rising edge of `tsr_empty`. It saturates at 3 and does not go below 0.
- R11: A difference between `mode_req` and `dma_mode` is applied only on a clock edge where `thr_empty` and `tsr_empty` are high and `tx_buf_status` is 0. Until the switch happens, `mode_busy` is high and the old mode stays in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | Requested mode, 1 = DMA, 0 = processor |
| rx_err_irq_en | input | 1 | Lets receive errors raise the receive interrupt |
| dma_mode | output | 1 | Mode currently in effect |
| mode_busy | output | 1 | A requested mode change is still pending |
| tx_buf_status | output | 2 | DMA-loaded characters still in the transmitter |
| thr_empty | input | 1 | Transmit holding register empty (from UART core) |
| tsr_empty | input | 1 | Transmit shift register empty (from UART core) |
| thr_load | output | 1 | Load strobe for the transmit holding register |
| thr_data | output | 8 | Character for the transmit holding register |
| rx_valid | input | 1 | Received character waiting (from UART core) |
| rx_data | input | 8 | Received character |
| rx_err | input | 4 | Receive error pulses: overrun, parity, framing, break |
| rx_take | output | 1 | Clears the UART core's data-ready condition |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_dma_ack | input | 1 | Transmit DMA acknowledge |
| tx_dma_data | input | 8 | Character written by the transmit DMA |
| tx_dma_done | input | 1 | Transmit DMA work unit finished |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_dma_ack | input | 1 | Receive DMA acknowledge |
| rx_dma_data | output | 8 | Character presented to the receive DMA |
| rx_dma_done | input | 1 | Receive DMA work unit finished |
| irq_clr_wr | input | 1 | Write strobe for interrupt clearing |
| irq_clr_data | input | 3 | Ones clear matching status bits |
| irq_status | output | 3 | Latched status: bit0 rx done, bit1 rx error, bit2 tx done |
| tx_irq | output | 1 | Transmit DMA interrupt |
| rx_irq | output | 1 | Receive DMA and error interrupt |

## Verification
The load and take strobes, the data paths and the interrupt ORs are combinational, so the bench checks them a moment after driving the acknowledge in the same cycle. Requests, status bits, the buffer counter and the mode flag are registered and appear one edge after their cause. A mode switch lands one edge after the edge at which the counter reaches zero, which makes it two edges after the last shift-register rise. Inputs change on the falling clock edge, and every registered result is sampled on the falling edge after the rising edge at which it is due.

// File: rtl/uart_dma_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the UART DMA handshake unit.
// Assumes: the status vector layout below is fixed and decoded by software.
package uart_dma_pkg;
    localparam int IRQ_W       = 3;
    localparam int IRQ_RX_DONE = 0;
    localparam int IRQ_RX_ERR  = 1;
    localparam int IRQ_TX_DONE = 2;
    localparam int N_CHAN      = 2;
    localparam int CH_RX       = 0;
    localparam int CH_TX       = 1;

    typedef enum logic {
        MODE_CPU = 1'b0,
        MODE_DMA = 1'b1
    } xfer_mode_e;
endpackage

// File: rtl/uart_dma_chan_hs.sv
`timescale 1ns/1ps
// Module: one-character request/acknowledge handshake for a DMA channel.
// Raises a registered request while enabled and the UART side is ready.
// The acknowledge is honoured only against a high request, and the request
// drops in the cycle after an honoured acknowledge.
// Assumes: the UART side drops 'ready' at the edge that consumes 'fire'.
module uart_dma_chan_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ready,
    input  logic ack,
    output logic req,
    output logic fire
);
    logic req_q;

    // Strobe: acknowledge met a live request.
    assign fire = req_q & ack;
    assign req  = req_q;

    // Request register: set while ready, dropped after an honoured acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= en & ready & ~fire;
    end
endmodule

// File: rtl/uart_dma_irq_stat.sv
`timescale 1ns/1ps
// Module: latched interrupt status with write-one-to-clear.
// An event in the same cycle as a clear of the same bit leaves it set.
// Assumes: 'set' bits are single-cycle event pulses.
module uart_dma_irq_stat #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic         clr_wr,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status
);
    logic [W-1:0] status_q;
    logic [W-1:0] clr_eff;

    // Clear mask only counts on a write cycle.
    assign clr_eff = clr_wr ? clr_mask : '0;
    assign status  = status_q;

    // Status register: clear first, then events win.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_eff) | set;
    end
endmodule

// File: rtl/uart_dma_mode_ctl.sv
`timescale 1ns/1ps
// Module: mode switch guard and transmit in-flight counter.
// Counts DMA-loaded characters up on each load and down on each rising
// edge of the shift-register-empty flag, saturating at both ends.
// Applies a requested mode change only when the transmitter is drained.
// Assumes: tsr_empty rises once for each character shifted out.
module uart_dma_mode_ctl #(
    parameter int BUF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_req,
    input  logic             thr_empty,
    input  logic             tsr_empty,
    input  logic             load,
    output logic             dma_mode,
    output logic             busy,
    output logic [BUF_W-1:0] buf_cnt
);
    import uart_dma_pkg::*;

    localparam logic [BUF_W-1:0] BUF_MAX = {BUF_W{1'b1}};

    xfer_mode_e       mode_q;
    logic [BUF_W-1:0] cnt_q;
    logic             tsr_prev_q;
    logic             inc, dec, drained;

    assign inc     = load & (cnt_q != BUF_MAX);
    assign dec     = tsr_empty & ~tsr_prev_q & (cnt_q != '0);
    assign drained = thr_empty & tsr_empty & (cnt_q == '0);

    assign dma_mode = (mode_q == MODE_DMA);
    assign busy     = mode_req ^ dma_mode;
    assign buf_cnt  = cnt_q;

    // Edge detector for the shift register empty flag.
    always_ff @(posedge clk) begin
        if (!rst_n) tsr_prev_q <= 1'b1;
        else        tsr_prev_q <= tsr_empty;
    end

    // In-flight counter: up on load, down on shift completion.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Mode register: follows the request only when drained.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= MODE_CPU;
        else if (busy && drained)  mode_q <= mode_req ? MODE_DMA : MODE_CPU;
    end
endmodule

// File: rtl/uart_dma_bridge.sv
`timescale 1ns/1ps
// Module: UART DMA handshake and interrupt unit (top).
// Connects a UART core's holding registers to receive and transmit DMA
// channels, one character per handshake. It keeps latched W1C interrupt
// status per channel and guards mode changes on a drained transmitter.
// Assumes: the UART core updates thr_empty / rx_valid at the edge of a
// load / take strobe; done and error inputs are single-cycle pulses.
module uart_dma_bridge #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4,
    parameter int BUF_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           mode_req,
    input  logic                           rx_err_irq_en,
    output logic                           dma_mode,
    output logic                           mode_busy,
    output logic [BUF_W-1:0]               tx_buf_status,
    input  logic                           thr_empty,
    input  logic                           tsr_empty,
    output logic                           thr_load,
    output logic [DATA_W-1:0]              thr_data,
    input  logic                           rx_valid,
    input  logic [DATA_W-1:0]              rx_data,
    input  logic [ERR_W-1:0]               rx_err,
    output logic                           rx_take,
    output logic                           tx_dma_req,
    input  logic                           tx_dma_ack,
    input  logic [DATA_W-1:0]              tx_dma_data,
    input  logic                           tx_dma_done,
    output logic                           rx_dma_req,
    input  logic                           rx_dma_ack,
    output logic [DATA_W-1:0]              rx_dma_data,
    input  logic                           rx_dma_done,
    input  logic                           irq_clr_wr,
    input  logic [uart_dma_pkg::IRQ_W-1:0] irq_clr_data,
    output logic [uart_dma_pkg::IRQ_W-1:0] irq_status,
    output logic                           tx_irq,
    output logic                           rx_irq
);
    import uart_dma_pkg::*;

    logic [N_CHAN-1:0] ch_ready, ch_ack, ch_req, ch_fire;
    logic [IRQ_W-1:0]  irq_set;

    assign ch_ready[CH_RX] = rx_valid;
    assign ch_ready[CH_TX] = thr_empty;
    assign ch_ack[CH_RX]   = rx_dma_ack;
    assign ch_ack[CH_TX]   = tx_dma_ack;

    // One handshake engine per direction.
    for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
        uart_dma_chan_hs hs_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (dma_mode),
            .ready (ch_ready[c]),
            .ack   (ch_ack[c]),
            .req   (ch_req[c]),
            .fire  (ch_fire[c])
        );
    end

    assign rx_dma_req  = ch_req[CH_RX];
    assign tx_dma_req  = ch_req[CH_TX];
    assign rx_take     = ch_fire[CH_RX];
    assign thr_load    = ch_fire[CH_TX];
    assign thr_data    = tx_dma_data;
    assign rx_dma_data = rx_data;

    // Interrupt events: errors fold in only when enabled.
    assign irq_set[IRQ_RX_DONE] = rx_dma_done;
    assign irq_set[IRQ_RX_ERR]  = rx_err_irq_en & (|rx_err);
    assign irq_set[IRQ_TX_DONE] = tx_dma_done;

    uart_dma_irq_stat #(.W(IRQ_W)) stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (irq_set),
        .clr_wr   (irq_clr_wr),
        .clr_mask (irq_clr_data),
        .status   (irq_status)
    );

    assign tx_irq = irq_status[IRQ_TX_DONE];
    assign rx_irq = irq_status[IRQ_RX_DONE] | irq_status[IRQ_RX_ERR];

    uart_dma_mode_ctl #(.BUF_W(BUF_W)) mode_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (mode_req),
        .thr_empty (thr_empty),
        .tsr_empty (tsr_empty),
        .load      (thr_load),
        .dma_mode  (dma_mode),
        .busy      (mode_busy),
        .buf_cnt   (tx_buf_status)
    );
endmodule

// File: rtl/uart_dma_bridge_chk.sv
`timescale 1ns/1ps
// Module: assertion checker for uart_dma_bridge, attached by bind.
// Assumes: port names match the top module so '.*' connects them.
module uart_dma_bridge_chk #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 4,
    parameter int BUF_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_req,
    input logic              rx_err_irq_en,
    input logic              dma_mode,
    input logic              mode_busy,
    input logic [BUF_W-1:0]  tx_buf_status,
    input logic              thr_empty,
    input logic              tsr_empty,
    input logic              thr_load,
    input logic              rx_take,
    input logic              tx_dma_req,
    input logic              tx_dma_ack,
    input logic              tx_dma_done,
    input logic              rx_dma_req,
    input logic              rx_dma_ack,
    input logic              irq_clr_wr,
    input logic [2:0]        irq_status
);
    // R5: no requests follow a cycle in processor mode.
    assert_no_req_cpu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> (!tx_dma_req && !rx_dma_req));

    // R4: an acknowledge without a request strobes nothing.
    assert_ack_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_dma_ack && !tx_dma_req) |-> !thr_load) and
        ((rx_dma_ack && !rx_dma_req) |-> !rx_take));

    // R2: transmit request drops after an honoured acknowledge.
    assert_tx_req_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_req && tx_dma_ack) |=> !tx_dma_req);

    // R3: receive request drops after an honoured acknowledge.
    assert_rx_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_req && rx_dma_ack) |=> !rx_dma_req);

    // R8: with no clear write, no set status bit falls.
    assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_clr_wr |=> ((irq_status & $past(irq_status)) == $past(irq_status)));

    // R9: a transmit completion always leaves its bit set.
    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_done |=> irq_status[2]);

    // R7: with errors disabled and no error bit set, it stays clear.
    assert_err_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_err_irq_en && !irq_status[1]) |=> !irq_status[1]);

    // R11: mode holds while the transmitter is not drained.
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_empty || !tsr_empty || tx_buf_status != '0) |=> $stable(dma_mode));
endmodule

bind uart_dma_bridge uart_dma_bridge_chk #(
    .DATA_W (DATA_W),
    .ERR_W  (ERR_W),
    .BUF_W  (BUF_W)
) chk_i (.*);

// File: tb/uart_dma_bridge_tb_top.sv
`timescale 1ns/1ps
// Directed bench for uart_dma_bridge: one task per scenario, each checking
// its own results. Inputs change on the falling edge; registered outputs
// are sampled on the falling edge after the rising edge that produces them.
module uart_dma_bridge_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_req, rx_err_irq_en;
    logic       dma_mode, mode_busy;
    logic [1:0] tx_buf_status;
    logic       thr_empty, tsr_empty, thr_load;
    logic [7:0] thr_data;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [3:0] rx_err;
    logic       rx_take;
    logic       tx_dma_req, tx_dma_ack, tx_dma_done;
    logic [7:0] tx_dma_data;
    logic       rx_dma_req, rx_dma_ack, rx_dma_done;
    logic [7:0] rx_dma_data;
    logic       irq_clr_wr;
    logic [2:0] irq_clr_data, irq_status;
    logic       tx_irq, rx_irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    uart_dma_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .rx_err_irq_en(rx_err_irq_en),
        .dma_mode(dma_mode), .mode_busy(mode_busy), .tx_buf_status(tx_buf_status),
        .thr_empty(thr_empty), .tsr_empty(tsr_empty), .thr_load(thr_load),
        .thr_data(thr_data), .rx_valid(rx_valid), .rx_data(rx_data), .rx_err(rx_err),
        .rx_take(rx_take), .tx_dma_req(tx_dma_req), .tx_dma_ack(tx_dma_ack),
        .tx_dma_data(tx_dma_data), .tx_dma_done(tx_dma_done), .rx_dma_req(rx_dma_req),
        .rx_dma_ack(rx_dma_ack), .rx_dma_data(rx_dma_data), .rx_dma_done(rx_dma_done),
        .irq_clr_wr(irq_clr_wr), .irq_clr_data(irq_clr_data), .irq_status(irq_status),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    // Wait for a transmit request, then acknowledge it once with 'd'.
    task automatic tx_load(input logic [7:0] d);
        for (int i = 0; i < 8 && !tx_dma_req; i++) @(negedge clk);
        chk("R2 req before load", tx_dma_req, 1'b1);
        tx_dma_ack = 1'b1; tx_dma_data = d;
        #0.5;
        chk("R2 load strobe", thr_load, 1'b1);
        chk("R2 load data", thr_data, d);
        @(negedge clk);
        tx_dma_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_req = 1'b0; rx_err_irq_en = 1'b0;
        thr_empty = 1'b1; tsr_empty = 1'b1; rx_valid = 1'b0; rx_data = '0; rx_err = '0;
        tx_dma_ack = 1'b0; tx_dma_data = '0; tx_dma_done = 1'b0;
        rx_dma_ack = 1'b0; rx_dma_done = 1'b0; irq_clr_wr = 1'b0; irq_clr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 mode", dma_mode, 1'b0);
        chk("R1 reqs", {tx_dma_req, rx_dma_req}, 2'b00);
        chk("R1 status", irq_status, 3'b000);
        chk("R1 irqs", {tx_irq, rx_irq}, 2'b00);
        chk("R1 buf", tx_buf_status, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cpu_mode();
        thr_empty = 1'b1; rx_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R5 no reqs in cpu mode", {tx_dma_req, rx_dma_req}, 2'b00);
        end
        rx_valid = 1'b0;
    endtask

    task automatic t_enter_dma();
        thr_empty = 1'b1; tsr_empty = 1'b0; mode_req = 1'b1;
        @(negedge clk);
        chk("R11 held mode", dma_mode, 1'b0);
        chk("R11 busy", mode_busy, 1'b1);
        repeat (3) @(negedge clk);
        chk("R11 still held", dma_mode, 1'b0);
        tsr_empty = 1'b1;
        @(negedge clk);
        chk("R11 switched", dma_mode, 1'b1);
        chk("R11 busy clear", mode_busy, 1'b0);
    endtask

    task automatic t_tx();
        @(negedge clk);
        tx_load(8'h5A);
        thr_empty = 1'b0;
        chk("R2 req low after ack", tx_dma_req, 1'b0);
        chk("R10 count after load", tx_buf_status, 2'd1);
        @(negedge clk);
        chk("R2 req low while full", tx_dma_req, 1'b0);
    endtask

    task automatic t_rx();
        rx_valid = 1'b1; rx_data = 8'hC3;
        rx_dma_ack = 1'b1; tx_dma_ack = 1'b1;
        #0.5;
        chk("R4 rx ack without req", rx_take, 1'b0);
        chk("R4 tx ack without req", thr_load, 1'b0);
        @(negedge clk);
        rx_dma_ack = 1'b0; tx_dma_ack = 1'b0;
        chk("R3 rx req", rx_dma_req, 1'b1);
        rx_dma_ack = 1'b1;
        #0.5;
        chk("R3 take strobe", rx_take, 1'b1);
        chk("R3 rx data", rx_dma_data, 8'hC3);
        @(negedge clk);
        rx_dma_ack = 1'b0; rx_valid = 1'b0;
        chk("R3 req low after ack", rx_dma_req, 1'b0);
    endtask

    task automatic t_irq();
        tx_dma_done = 1'b1;
        @(negedge clk); tx_dma_done = 1'b0;
        chk("R6 tx done bit", irq_status, 3'b100);
        chk("R6 tx irq only", {tx_irq, rx_irq}, 2'b10);
        irq_clr_wr = 1'b1; irq_clr_data = 3'b011;
        @(negedge clk); irq_clr_wr = 1'b0;
        chk("R8 zero write keeps bit", irq_status, 3'b100);
        irq_clr_wr = 1'b1; irq_clr_data = 3'b100;
        @(negedge clk); irq_clr_wr = 1'b0;
        chk("R8 one write clears", irq_status, 3'b000);
        chk("R8 tx irq low", tx_irq, 1'b0);
        rx_err_irq_en = 1'b0; rx_err = 4'b0010;
        @(negedge clk); rx_err = '0;
        chk("R7 error masked", {irq_status, rx_irq}, 4'b0000);
        rx_err_irq_en = 1'b1; rx_err = 4'b1000;
        @(negedge clk); rx_err = '0;
        chk("R7 error latched", irq_status, 3'b010);
        chk("R7 rx irq", {tx_irq, rx_irq}, 2'b01);
        rx_dma_done = 1'b1; irq_clr_wr = 1'b1; irq_clr_data = 3'b001;
        @(negedge clk); rx_dma_done = 1'b0; irq_clr_wr = 1'b0;
        chk("R9 set beats clear", irq_status, 3'b011);
        irq_clr_wr = 1'b1; irq_clr_data = 3'b111;
        @(negedge clk); irq_clr_wr = 1'b0;
        chk("R8 all cleared", {irq_status, rx_irq}, 4'b0000);
    endtask

    task automatic t_buf();
        thr_empty = 1'b1; tsr_empty = 1'b0;
        tx_load(8'h11);
        chk("R10 count 2", tx_buf_status, 2'd2);
        tx_load(8'h22);
        chk("R10 count 3", tx_buf_status, 2'd3);
        tx_load(8'h33);
        chk("R10 saturate", tx_buf_status, 2'd3);
    endtask

    task automatic t_exit();
        mode_req = 1'b0;
        @(negedge clk);
        chk("R11 exit held", {dma_mode, mode_busy}, 2'b11);
        for (int k = 0; k < 2; k++) begin
            tsr_empty = 1'b1; @(negedge clk);
            tsr_empty = 1'b0; @(negedge clk);
        end
        chk("R10 count down", tx_buf_status, 2'd1);
        chk("R11 held on count", dma_mode, 1'b1);
        tsr_empty = 1'b1;
        @(negedge clk);
        chk("R10 count zero", tx_buf_status, 2'd0);
        chk("R11 not yet", dma_mode, 1'b1);
        @(negedge clk);
        chk("R11 exit done", {dma_mode, mode_busy}, 2'b00);
        @(negedge clk);
        chk("R5 req low after exit", tx_dma_req, 1'b0);
        tsr_empty = 1'b0; @(negedge clk);
        tsr_empty = 1'b1; @(negedge clk);
        chk("R10 floor at zero", tx_buf_status, 2'd0);
    endtask

    initial begin
        t_reset();
        t_cpu_mode();
        t_enter_dma();
        t_tx();
        t_rx();
        t_irq();
        t_buf();
        t_exit();
        summary();
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end
endmodule